// File: doc/BRIEF.md
# Latched Interrupt Mask Priority Controller

This block collects interrupt events for a processor core. It holds them in a latch register, gates them with a mask register and picks the single winner the core should take next. Hardware event pulses set latch bits. Software can rewrite the whole latch, either to raise a software interrupt or to drop a pending one.

A separate mask register decides which latched bits may reach the core. A masked event is not lost: it stays pending and is taken as soon as its mask bit is set. Two top-ranked positions cannot be masked, whatever is written to the mask:

- the reset interrupt at bit 0;
- the high-rank emulator interrupt at bit 1.

The block presents a registered request flag and the index of the winning bit. The lowest index ranks highest. The core answers with a one-cycle acknowledge that carries the index it took, and that clears the serviced latch bit.

The low-rank emulator interrupt at bit 27 is set on reset and whenever its event input pulses. Bits 28 to 31 are the four software interrupts. All five rank below every lower-numbered source.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Immediately after reset the latch reads 0x0800_0000 (only bit 27 pending), the mask reads 0x0000_0003 and irq_req is 0.
- R2: A mask write replaces the mask at the next clock edge. A mask bit of 1 lets the latched bit at the same position compete, and a mask bit of 0 keeps it out.
- R3: Mask bits 0 and 1 always read 1 and always let their latched bits compete, whatever value is written to them.
- R4: A latched bit whose mask bit is 0 stays in the latch, and it is requested once its mask bit is set.
- R5: A 1 on hw_evt[i] sets latch bit i at the next edge. This wins over a latch write of 0 to that bit and over an acknowledge of that bit in the same cycle.
- R6: When irq_req is 1, irq_idx is the lowest index i that was both latched and enabled.
- R7: An acknowledge (ack_valid=1, ack_idx=i) clears latch bit i at the next edge.
- R8: A latch write replaces the latch with lat_wr_data: a data bit of 1 sets the latch bit and a 0 clears it. An acknowledge in the same cycle also clears its bit.
- R9: Writing 1 to latch bits 28 to 31 raises software interrupts 0 to 3. When pending and enabled, bit 27 is requested ahead of all of them.
- R10: irq_req and irq_idx are registered one cycle behind the latch and mask. irq_req is 0 and irq_idx is 0 when no latched bit is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hw_evt | input | 32 | Hardware event pulses, one per latch bit |
| lat_wr_en | input | 1 | Latch write strobe |
| lat_wr_data | input | 32 | New latch contents |
| msk_wr_en | input | 1 | Mask write strobe |
| msk_wr_data | input | 32 | New mask contents (bits 0 and 1 forced to 1) |
| ack_valid | input | 1 | Acknowledge strobe from the core |
| ack_idx | input | 5 | Index of the bit being acknowledged |
| latch_q | output | 32 | Current latch contents |
| mask_q | output | 32 | Current effective mask |
| irq_req | output | 1 | Registered request flag |
| irq_idx | output | 5 | Registered index of the winning bit |

## Verification
The bench uses the default parameters: 32 sources, the reset bit at 0, the high-rank emulator bit at 1 and the low-rank emulator bit at 27. With these values it can check the exact reset image (0x0800_0003 across latch and mask). It can also check that bit 27 beats software bit 28, and that bit 31 is still chosen when it is the only source enabled.

Collisions are driven on purpose: an event against a latch clear, and an event against an acknowledge of the same bit. The one-cycle lag of the request behind the latch is checked cycle by cycle against an independent model.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int IRQ_NUM    = 32;
  localparam int RST_POS    = 0;
  localparam int EMU_HI_POS = 1;
  localparam int EMU_LO_POS = 27;
endpackage

// File: rtl/irq_latch_bank.sv
module irq_latch_bank #(
  parameter int N = 32,
  parameter logic [N-1:0] RST_VAL = '0,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     hw_evt,
  input  logic             wr_en,
  input  logic [N-1:0]     wr_data,
  input  logic             ack_valid,
  input  logic [IDX_W-1:0] ack_idx,
  output logic [N-1:0]     latch_q
);
  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  // clear vector: one-hot on the acknowledged index
  function automatic logic [N-1:0] ack_vec(input logic v, input logic [IDX_W-1:0] i);
    return v ? (ONE << i) : '0;
  endfunction

  // update order: write replaces, ack clears, events set last (they win)
  function automatic logic [N-1:0] next_latch(input logic [N-1:0] cur,
                                              input logic we,
                                              input logic [N-1:0] wd,
                                              input logic [N-1:0] clr,
                                              input logic [N-1:0] set);
    logic [N-1:0] base;
    base = we ? wd : cur;
    return (base & ~clr) | set;
  endfunction

  logic [N-1:0] clr_vec;
  logic [N-1:0] latch_d;

  assign clr_vec = ack_vec(ack_valid, ack_idx);
  assign latch_d = next_latch(latch_q, wr_en, wr_data, clr_vec, hw_evt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= RST_VAL;
    else        latch_q <= latch_d;
  end

  AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_evt != '0) |=> ((latch_q & $past(hw_evt)) == $past(hw_evt))); // R5

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !wr_en && ((hw_evt & (ONE << ack_idx)) == '0))
      |=> ((latch_q & (ONE << $past(ack_idx))) == '0)); // R7

  AST_WR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ack_valid) |=> ((latch_q & $past(wr_data)) == $past(wr_data))); // R8
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int N = 32,
  parameter logic [N-1:0] FORCED = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [N-1:0] wr_data,
  output logic [N-1:0] mask_q
);
  // non-maskable positions are pinned to 1 on every write
  function automatic logic [N-1:0] pin_forced(input logic [N-1:0] d);
    return d | FORCED;
  endfunction

  logic [N-1:0] mask_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mask_r <= FORCED;
    else if (wr_en) mask_r <= pin_forced(wr_data);
  end

  assign mask_q = mask_r;

  AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((mask_q & ~FORCED) == ($past(wr_data) & ~FORCED))); // R2
endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver #(
  parameter int N = 32,
  parameter int TOP_BIT = 0,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     latch_q,
  input  logic [N-1:0]     mask_q,
  output logic             irq_req,
  output logic [IDX_W-1:0] irq_idx
);
  // lowest set index, 0 when empty
  function automatic logic [IDX_W-1:0] lowest_set(input logic [N-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  logic [N-1:0]     pend_vec;
  logic             any_pend;
  logic [IDX_W-1:0] win_idx;

  assign pend_vec = latch_q & mask_q;
  assign any_pend = |pend_vec;
  assign win_idx  = lowest_set(pend_vec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_req <= 1'b0;
      irq_idx <= '0;
    end else begin
      irq_req <= any_pend;
      irq_idx <= win_idx;
    end
  end

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_vec == '0) |=> (!irq_req && irq_idx == '0)); // R10

  AST_TOP_ALWAYS_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
    latch_q[TOP_BIT] |=> (irq_req && irq_idx == IDX_W'(TOP_BIT))); // R3

  AST_WINNER_WAS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ((($past(latch_q) & $past(mask_q)) >> irq_idx) & {{(N-1){1'b0}}, 1'b1}) != '0); // R6
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int N          = irq_pkg::IRQ_NUM,
  parameter int RST_BIT    = irq_pkg::RST_POS,
  parameter int EMU_HI_BIT = irq_pkg::EMU_HI_POS,
  parameter int EMU_LO_BIT = irq_pkg::EMU_LO_POS,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     hw_evt,
  input  logic             lat_wr_en,
  input  logic [N-1:0]     lat_wr_data,
  input  logic             msk_wr_en,
  input  logic [N-1:0]     msk_wr_data,
  input  logic             ack_valid,
  input  logic [IDX_W-1:0] ack_idx,
  output logic [N-1:0]     latch_q,
  output logic [N-1:0]     mask_q,
  output logic             irq_req,
  output logic [IDX_W-1:0] irq_idx
);
  localparam logic [N-1:0] ONE       = {{(N-1){1'b0}}, 1'b1};
  localparam logic [N-1:0] NMI_BITS  = (ONE << RST_BIT) | (ONE << EMU_HI_BIT);
  localparam logic [N-1:0] LATCH_RST = ONE << EMU_LO_BIT;

  irq_latch_bank #(.N(N), .RST_VAL(LATCH_RST)) u_latch (
    .clk(clk), .rst_n(rst_n), .hw_evt(hw_evt),
    .wr_en(lat_wr_en), .wr_data(lat_wr_data),
    .ack_valid(ack_valid), .ack_idx(ack_idx),
    .latch_q(latch_q)
  );

  irq_mask_reg #(.N(N), .FORCED(NMI_BITS)) u_mask (
    .clk(clk), .rst_n(rst_n),
    .wr_en(msk_wr_en), .wr_data(msk_wr_data),
    .mask_q(mask_q)
  );

  irq_prio_resolver #(.N(N), .TOP_BIT(RST_BIT)) u_resolve (
    .clk(clk), .rst_n(rst_n),
    .latch_q(latch_q), .mask_q(mask_q),
    .irq_req(irq_req), .irq_idx(irq_idx)
  );

  AST_MASK_PINNED: assert property (@(posedge clk) disable iff (!rst_n)
    msk_wr_en |=> ((mask_q & NMI_BITS) == NMI_BITS)); // R3

  AST_MASKED_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!lat_wr_en && !ack_valid && ((latch_q & ~mask_q) != '0))
      |=> ((latch_q & $past(latch_q & ~mask_q)) == $past(latch_q & ~mask_q))); // R4
endmodule

// File: tb/irq_prio_ctrl_bench.sv
`timescale 1ns/1ps
module irq_prio_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] hw_evt = '0;
  logic        lat_wr_en = 1'b0;
  logic [31:0] lat_wr_data = '0;
  logic        msk_wr_en = 1'b0;
  logic [31:0] msk_wr_data = '0;
  logic        ack_valid = 1'b0;
  logic [4:0]  ack_idx = '0;
  logic [31:0] latch_q, mask_q;
  logic        irq_req;
  logic [4:0]  irq_idx;

  always #2.5 clk = ~clk;

  irq_prio_ctrl u_irq_prio_ctrl (
    .clk(clk), .rst_n(rst_n), .hw_evt(hw_evt),
    .lat_wr_en(lat_wr_en), .lat_wr_data(lat_wr_data),
    .msk_wr_en(msk_wr_en), .msk_wr_data(msk_wr_data),
    .ack_valid(ack_valid), .ack_idx(ack_idx),
    .latch_q(latch_q), .mask_q(mask_q),
    .irq_req(irq_req), .irq_idx(irq_idx)
  );

  typedef struct {
    string       tag;
    logic        req;
    logic [4:0]  idx;
    logic [31:0] lat;
    logic [31:0] msk;
  } exp_t;

  exp_t q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 0;

  // reference state
  logic [31:0] m_lat, m_msk;
  logic        m_req;
  logic [4:0]  m_idx;

  function automatic logic [4:0] pick(input logic [31:0] v);
    for (int b = 0; b < 32; b++) if (v[b]) return 5'(b);
    return 5'd0;
  endfunction

  task automatic push(input string tag);
    exp_t e;
    e.tag = tag; e.req = m_req; e.idx = m_idx; e.lat = m_lat; e.msk = m_msk;
    q.push_back(e);
  endtask

  // drive one cycle of stimulus, advance the model, queue the expectation
  task automatic tick(input string tag, input logic [31:0] evt,
                      input logic lw, input logic [31:0] ld,
                      input logic mw, input logic [31:0] md,
                      input logic av, input logic [4:0] ai);
    logic        nr;
    logic [4:0]  ni;
    logic [31:0] pend;
    hw_evt = evt; lat_wr_en = lw; lat_wr_data = ld;
    msk_wr_en = mw; msk_wr_data = md; ack_valid = av; ack_idx = ai;
    @(posedge clk);
    pend  = m_lat & m_msk;
    nr    = (pend != 0);
    ni    = pick(pend);
    m_lat = ((lw ? ld : m_lat) & ~(av ? (32'd1 << ai) : 32'd0)) | evt;
    if (mw) m_msk = md | 32'h3;
    m_req = nr; m_idx = ni;
    #1;
    hw_evt = '0; lat_wr_en = 0; lat_wr_data = '0;
    msk_wr_en = 0; msk_wr_data = '0; ack_valid = 0; ack_idx = '0;
    push(tag);
  endtask

  task automatic idle(input string tag);
    tick(tag, 32'd0, 0, 32'd0, 0, 32'd0, 0, 5'd0);
  endtask

  // monitor: compare at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_cmp++;
        if (irq_req !== e.req || irq_idx !== e.idx || latch_q !== e.lat || mask_q !== e.msk) begin
          n_bad++;
          $display("FAIL %s: req=%0b idx=%0d lat=%h msk=%h expected req=%0b idx=%0d lat=%h msk=%h",
                   e.tag, irq_req, irq_idx, latch_q, mask_q, e.req, e.idx, e.lat, e.msk);
        end
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    m_lat = 32'h0800_0000; m_msk = 32'h3; m_req = 0; m_idx = 0;
    repeat (3) @(posedge clk);
    #1;
    push("R1 reset image");
    @(negedge clk); #1;
    rst_n = 1'b1;
    idle("R1 bit27 pending but masked");
    // R2 enable bit 27
    tick("R2 mask write", 0, 0, 0, 1, 32'h0800_0000, 0, 0);
    idle("R2 enabled bit requested");
    // R7 acknowledge
    tick("R7 ack clears", 0, 0, 0, 0, 0, 1, 5'd27);
    idle("R10 request drops one cycle later");
    // R8 / R9 latch write, both masked
    tick("R8 R9 latch write sets", 0, 1, 32'h1000_0020, 0, 0, 0, 0);
    idle("R4 masked bits stay latched");
    idle("R4 no request while masked");
    tick("R4 unmask", 0, 0, 0, 1, 32'h1800_0020, 0, 0);
    idle("R4 R6 lowest enabled wins");
    // R9 emulator-low event ranks above software
    tick("R9 emu low event", 32'h0800_0000, 0, 0, 0, 0, 0, 0);
    tick("R7 ack bit5", 0, 0, 0, 0, 0, 1, 5'd5);
    idle("R9 bit27 before bit28");
    tick("R7 ack bit27", 0, 0, 0, 0, 0, 1, 5'd27);
    idle("R9 software bit28");
    tick("R7 ack bit28", 0, 0, 0, 0, 0, 1, 5'd28);
    idle("R10 idle after drain");
    // R3 non-maskable bits
    tick("R3 mask write zero", 0, 0, 0, 1, 32'h0, 0, 0);
    tick("R3 hw bit1", 32'h0000_0002, 0, 0, 0, 0, 0, 0);
    idle("R3 bit1 served unmasked");
    tick("R6 bits0 and 31", 32'h8000_0001, 0, 0, 0, 0, 0, 0);
    idle("R6 bit0 wins");
    // R5 collisions
    tick("R5 event vs ack", 32'h0000_0001, 0, 0, 0, 0, 1, 5'd0);
    idle("R5 bit0 still pending");
    tick("R5 event vs write clear", 32'h0000_0004, 1, 32'h0, 0, 0, 0, 0);
    idle("R5 R10 only masked bit2");
    idle("R10 request low");
    tick("R8 write with ack", 0, 1, 32'h8000_0003, 0, 0, 1, 5'd1);
    idle("R8 ack beats write data");
    tick("R7 ack bit0", 0, 0, 0, 0, 0, 1, 5'd0);
    tick("R6 enable bit31", 0, 0, 0, 1, 32'h8000_0000, 0, 0);
    idle("R6 top index served");
    idle("R6 top index steady");
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule